// File: doc/BRIEF.md
# I2C Master Byte Transfer Sequencer

This block runs the master side of I2C transactions at the byte level. It does not drive SCL or SDA. Instead it issues abstract commands (start with address, write byte, read byte, stop) to a bus engine. The engine answers each command with an acknowledge flag and, for reads, a data byte. Software sets up a 16-bit transfer count and a control word, and moves data through a four-byte buffer. That buffer holds outgoing bytes in transmit direction and incoming bytes in receive direction.

A transfer begins when the control word has enable, master and start set and 10-bit addressing clear. In counted mode, the working count is loaded when the start is acknowledged. The count drops by one for every data byte moved. When the count reaches zero, the pending stop bit selects the ending:
- With the stop bit set, the block issues a stop.
- Without it, the block pulses access-ready, clears the master bit and leaves the bus held, so that a repeated start can follow.

In repeat mode the count is not used. The block streams bytes until software sets the stop bit.

The controller is a four-state machine:
- `ST_IDLE` waits for a start request and takes the *start* transition into `ST_CMD`.
- `ST_RUN` makes the data, stop or ready decision each cycle. It takes the *issue* transition to `ST_CMD`, the *release* transition (access ready) to `ST_IDLE`, or waits in place for buffer space or data.
- `ST_CMD` presents one command until the engine takes it (the *accept* transition to `ST_RSP`).
- `ST_RSP` waits for the answer. It takes the *continue* transition to `ST_RUN`, or the *finish* transition (stop done or NACK) to `ST_IDLE`.

A control write with enable clear is the *abort* transition. It goes from any state to `ST_IDLE`.

Top module: `i2c_xfer_seq`

## Requirements
- R1: Control writes store only the bits under mask 0xCF87, and the register is read back on `ctrl_o`. The bit positions are:
  - start: bit 0
  - stop: bit 1
  - repeat mode: bit 2
  - 10-bit addressing: bit 8
  - transmit: bit 9
  - master: bit 10
  - enable: bit 15

  After reset the register reads 0.
- R2: A start is taken only when enable, master and start are 1 and 10-bit addressing is 0. A slave-mode or 10-bit setting is stored but issues no command. A taken start clears the start bit, empties the buffer and issues op START (code 0) with byte {address, read}, where read is the inverse of the transmit bit.
- R3: A NACKed start pulses `nack_o`, clears the stop bit, leaves `bus_busy_o` low and issues no further command.
- R4: In counted transmit, buffered bytes go out as op WRITE (code 1) in push order, one per count step. `xrdy_o` is high while the count is non-zero and the buffer is empty.
- R5: In counted receive, op READ (code 2) is issued while the count is non-zero and fewer than 4 bytes are buffered. `rrdy_o` is high whenever receive direction is selected and the buffer holds bytes, and pops return bytes in arrival order.
- R6: At count zero with stop set, op STOP (code 3) is issued. The stop bit is then cleared, the working count is reloaded from the count setting and `bus_busy_o` falls. A count setting of 0 goes from START straight to STOP.
- R7: At count zero with stop clear, `ardy_o` pulses, the master bit clears and `bus_busy_o` stays high. A new start then issues START again without a STOP.
- R8: In repeat mode the count is ignored and left unchanged. Transmit sends every pushed byte, receive fills the buffer to 4 bytes, and a stop bit set later issues STOP.
- R9: A NACKed data write pulses `nack_o`, cancels a pending stop and ends command issue with the bus still held.
- R10: A control write with enable 0 aborts at once. It drops `cmd_valid_o`, empties the buffer and clears `bus_busy_o`.
- R11: A command keeps its op and byte until `cmd_ready_i` takes it, and only one command is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 16 | Control write value |
| count_we_i | input | 1 | Count setting write strobe |
| count_wdata_i | input | 16 | Count setting value |
| slave_addr_i | input | 7 | Target slave address |
| data_we_i | input | 1 | Push one byte to the buffer (transmit direction) |
| data_wdata_i | input | 8 | Byte to push |
| data_re_i | input | 1 | Pop one byte from the buffer (receive direction) |
| data_rdata_o | output | 8 | Buffer head byte |
| ctrl_o | output | 16 | Control register contents |
| count_o | output | 16 | Working count |
| bus_busy_o | output | 1 | Bus held after an acknowledged start |
| xrdy_o | output | 1 | Waiting for transmit bytes |
| rrdy_o | output | 1 | Received bytes available |
| ardy_o | output | 1 | Access-ready pulse |
| nack_o | output | 1 | NACK pulse |
| cmd_valid_o | output | 1 | Command valid to bus engine |
| cmd_ready_i | input | 1 | Bus engine accepts command |
| cmd_op_o | output | 2 | Command op code |
| cmd_byte_o | output | 8 | Command byte (address or data) |
| rsp_valid_i | input | 1 | Response valid |
| rsp_ack_i | input | 1 | Response acknowledge flag |
| rsp_data_i | input | 8 | Read data |

## Verification
The transaction logic is driven with several patterns, each separating a different part of it:
- Random counted transmits and receives with random lengths and addresses confirm that the count, not the buffer fill, decides when STOP is issued.
- A zero count checks that START is followed directly by STOP.
- A transfer without the stop bit separates the access-ready ending from the stop ending and is followed by a repeated start.
- A repeat-mode stream longer than the count proves that the count is ignored.
- NACKs injected on the start and on the second data byte tell apart the two error paths.
- A receive abort with a full buffer shows that the buffer is emptied.

The bus model answers after random delays and takes commands with random ready, so the command log exposes any duplicated or dropped handshake.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_CMD  = 2'd2,
        ST_RSP  = 2'd3
    } seq_state_e;

    localparam int CTRL_W = 16;
    localparam logic [CTRL_W-1:0] CTRL_MASK = 16'hCF87;

    localparam int B_STT = 0;
    localparam int B_STP = 1;
    localparam int B_RPT = 2;
    localparam int B_XA  = 8;
    localparam int B_TRX = 9;
    localparam int B_MST = 10;
    localparam int B_EN  = 15;

endpackage

// File: rtl/i2c_seq_fifo.sv
module i2c_seq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [AW:0]   level_q;
    logic          push_ok, pop_ok;

    assign empty_o = (level_q == '0);
    assign full_o  = (level_q == (AW+1)'(DEPTH));
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign head_o  = mem_q[rd_ptr_q];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else if (flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
            level_q <= level_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_ok && !flush_i) mem_q[wr_ptr_q] <= push_data_i;
    end
endmodule

// File: rtl/i2c_seq_count.sv
module i2c_seq_count #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] val_o,
    output logic         zero_o
);
    logic [W-1:0] val_q;

    assign val_o  = val_q;
    assign zero_o = (val_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               val_q <= '0;
        else if (load_i)           val_q <= load_val_i;
        else if (dec_i && !zero_o) val_q <= val_q - 1'b1;
    end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2c_seq_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8,
    parameter int BUF_DEPTH = 4,
    parameter int CNT_W     = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              count_we_i,
    input  logic [CNT_W-1:0]  count_wdata_i,
    input  logic [ADDR_W-1:0] slave_addr_i,
    input  logic              data_we_i,
    input  logic [DATA_W-1:0] data_wdata_i,
    input  logic              data_re_i,
    output logic [DATA_W-1:0] data_rdata_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              bus_busy_o,
    output logic              xrdy_o,
    output logic              rrdy_o,
    output logic              ardy_o,
    output logic              nack_o,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [1:0]        cmd_op_o,
    output logic [DATA_W-1:0] cmd_byte_o,
    input  logic              rsp_valid_i,
    input  logic              rsp_ack_i,
    input  logic [DATA_W-1:0] rsp_data_i
);
    localparam int ADDR_BYTE_W = ADDR_W + 1;

    seq_state_e        state_q, state_d;
    bus_op_e           op_q, op_d;
    logic [DATA_W-1:0] byte_q, byte_d;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cnt_cfg_q;
    logic              busy_q, ardy_q, nack_q;

    logic seq_pop, seq_push, flush, cnt_load, cnt_dec;
    logic clr_stt, clr_stp, clr_mst, ardy_d, nack_d, busy_set, busy_clr;
    logic [DATA_W-1:0] buf_head;
    logic buf_empty, buf_full, cnt_zero;
    logic [CNT_W-1:0] cnt_val;

    logic trx, rpt, stp, abort, start_ok, host_push, host_pop;
    assign trx       = ctrl_q[B_TRX];
    assign rpt       = ctrl_q[B_RPT];
    assign stp       = ctrl_q[B_STP];
    assign abort     = ctrl_we_i && !ctrl_wdata_i[B_EN];
    assign start_ok  = ctrl_q[B_EN] && ctrl_q[B_MST] && ctrl_q[B_STT] && !ctrl_q[B_XA];
    assign host_push = data_we_i && trx && !buf_full;
    assign host_pop  = data_re_i && !trx && !buf_empty;

    i2c_seq_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) buf_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (flush),
        .push_i      (host_push || seq_push),
        .push_data_i (seq_push ? rsp_data_i : data_wdata_i),
        .pop_i       (host_pop || seq_pop),
        .head_o      (buf_head),
        .empty_o     (buf_empty),
        .full_o      (buf_full)
    );

    i2c_seq_count #(.W(CNT_W)) cnt_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (cnt_load),
        .load_val_i (cnt_cfg_q),
        .dec_i      (cnt_dec),
        .val_o      (cnt_val),
        .zero_o     (cnt_zero)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            op_q    <= OP_START;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            byte_q  <= byte_d;
        end
    end

    // Transitions and per-transition actions
    always_comb begin
        state_d  = state_q;
        op_d     = op_q;
        byte_d   = byte_q;
        seq_pop  = 1'b0;
        seq_push = 1'b0;
        flush    = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        clr_stt  = 1'b0;
        clr_stp  = 1'b0;
        clr_mst  = 1'b0;
        ardy_d   = 1'b0;
        nack_d   = 1'b0;
        busy_set = 1'b0;
        busy_clr = 1'b0;
        if (abort) begin
            state_d  = ST_IDLE;
            flush    = 1'b1;
            busy_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!ctrl_we_i && start_ok) begin
                        clr_stt = 1'b1;
                        flush   = 1'b1;
                        op_d    = OP_START;
                        byte_d  = DATA_W'(ADDR_BYTE_W'({slave_addr_i, !trx}));
                        state_d = ST_CMD;
                    end
                end
                ST_RUN: begin
                    if (rpt ? stp : (cnt_zero && stp)) begin
                        op_d    = OP_STOP;
                        byte_d  = '0;
                        state_d = ST_CMD;
                    end else if (!rpt && cnt_zero) begin
                        ardy_d  = 1'b1;
                        clr_mst = 1'b1;
                        state_d = ST_IDLE;
                    end else if (trx && !buf_empty) begin
                        seq_pop = 1'b1;
                        op_d    = OP_WRITE;
                        byte_d  = buf_head;
                        state_d = ST_CMD;
                    end else if (!trx && !buf_full) begin
                        op_d    = OP_READ;
                        byte_d  = '0;
                        state_d = ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (cmd_ready_i) state_d = ST_RSP;
                end
                ST_RSP: begin
                    if (rsp_valid_i) begin
                        unique case (op_q)
                            OP_START: begin
                                if (rsp_ack_i) begin
                                    busy_set = 1'b1;
                                    cnt_load = 1'b1;
                                    state_d  = ST_RUN;
                                end else begin
                                    nack_d   = 1'b1;
                                    clr_stp  = 1'b1;
                                    busy_clr = 1'b1;
                                    state_d  = ST_IDLE;
                                end
                            end
                            OP_WRITE: begin
                                cnt_dec = !rpt;
                                if (rsp_ack_i) begin
                                    state_d = ST_RUN;
                                end else begin
                                    nack_d  = 1'b1;
                                    clr_stp = 1'b1;
                                    state_d = ST_IDLE;
                                end
                            end
                            OP_READ: begin
                                seq_push = 1'b1;
                                cnt_dec  = !rpt;
                                state_d  = ST_RUN;
                            end
                            OP_STOP: begin
                                clr_stp  = 1'b1;
                                cnt_load = 1'b1;
                                flush    = trx;
                                busy_clr = 1'b1;
                                state_d  = ST_IDLE;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // Control, count setting, bus hold and status pulses
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q    <= '0;
            cnt_cfg_q <= '0;
            busy_q    <= 1'b0;
            ardy_q    <= 1'b0;
            nack_q    <= 1'b0;
        end else begin
            if (ctrl_we_i) begin
                ctrl_q <= ctrl_wdata_i & CTRL_MASK;
            end else begin
                if (clr_stt) ctrl_q[B_STT] <= 1'b0;
                if (clr_stp) ctrl_q[B_STP] <= 1'b0;
                if (clr_mst) ctrl_q[B_MST] <= 1'b0;
            end
            if (count_we_i) cnt_cfg_q <= count_wdata_i;
            if (busy_clr)      busy_q <= 1'b0;
            else if (busy_set) busy_q <= 1'b1;
            ardy_q <= ardy_d;
            nack_q <= nack_d;
        end
    end

    // Outputs
    always_comb begin
        cmd_valid_o  = (state_q == ST_CMD);
        cmd_op_o     = op_q;
        cmd_byte_o   = byte_q;
        ctrl_o       = ctrl_q;
        count_o      = cnt_val;
        bus_busy_o   = busy_q;
        ardy_o       = ardy_q;
        nack_o       = nack_q;
        data_rdata_o = buf_head;
        rrdy_o       = !trx && !buf_empty;
        xrdy_o       = (state_q == ST_RUN) && trx && buf_empty && (rpt ? !stp : !cnt_zero);
    end
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        ctrl_we_i,
    input logic [15:0] ctrl_wdata_i,
    input logic [15:0] ctrl_o,
    input logic        bus_busy_o,
    input logic        xrdy_o,
    input logic        rrdy_o,
    input logic        ardy_o,
    input logic        nack_o,
    input logic        cmd_valid_o,
    input logic        cmd_ready_i,
    input logic [1:0]  cmd_op_o,
    input logic [7:0]  cmd_byte_o
);
    assert_cmd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_o && !cmd_ready_i && !ctrl_we_i) |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_byte_o)));

    assert_ardy_master_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ardy_o && !$past(ctrl_we_i)) |-> !ctrl_o[10]);

    assert_nack_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (nack_o && !$past(ctrl_we_i)) |-> !ctrl_o[1]);

    assert_xrdy_idle_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xrdy_o |-> !cmd_valid_o);

    assert_rrdy_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rrdy_o |-> !ctrl_o[9]);

    assert_pulse_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ardy_o |-> !nack_o);

    assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_we_i && !ctrl_wdata_i[15]) |=> (!cmd_valid_o && !bus_busy_o));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (ctrl_we_i),
    .ctrl_wdata_i (ctrl_wdata_i),
    .ctrl_o       (ctrl_o),
    .bus_busy_o   (bus_busy_o),
    .xrdy_o       (xrdy_o),
    .rrdy_o       (rrdy_o),
    .ardy_o       (ardy_o),
    .nack_o       (nack_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_op_o     (cmd_op_o),
    .cmd_byte_o   (cmd_byte_o)
);

// File: tb/i2c_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module i2c_xfer_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        ctrl_we = 0, count_we = 0, data_we = 0, data_re = 0;
    logic [15:0] ctrl_wdata = 0, count_wdata = 0;
    logic [6:0]  slave_addr = 0;
    logic [7:0]  data_wdata = 0;
    logic        cmd_ready = 0, rsp_valid = 0, rsp_ack = 0;
    logic [7:0]  rsp_data = 0;
    logic [7:0]  data_rdata, cmd_byte;
    logic [15:0] ctrl_q, count_q;
    logic        busy, xrdy, rrdy, ardy, nack, cmd_valid;
    logic [1:0]  cmd_op;

    i2c_xfer_seq dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
        .count_we_i(count_we), .count_wdata_i(count_wdata),
        .slave_addr_i(slave_addr),
        .data_we_i(data_we), .data_wdata_i(data_wdata), .data_re_i(data_re),
        .data_rdata_o(data_rdata), .ctrl_o(ctrl_q), .count_o(count_q),
        .bus_busy_o(busy), .xrdy_o(xrdy), .rrdy_o(rrdy), .ardy_o(ardy), .nack_o(nack),
        .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op), .cmd_byte_o(cmd_byte),
        .rsp_valid_i(rsp_valid), .rsp_ack_i(rsp_ack), .rsp_data_i(rsp_data)
    );

    int n_checks = 0, n_err = 0, cyc = 0;
    bit done = 0;
    logic [9:0] lg [256];
    logic [9:0] ex [256];
    int lg_n = 0, ex_n = 0, wr_cnt = 0, rd_cnt = 0, exp_rd = 0, pend = 0;
    int nack_wr_at = -1, ardy_seen = 0, nack_seen = 0;
    bit nack_start = 0;
    logic p_ack;
    logic [7:0] p_data;

    function automatic logic [7:0] rd_val(int i);
        return 8'((i * 29) + 60);
    endfunction

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            finish_sim();
        end
    end

    // Bus engine model: random ready, random response delay, logs commands
    always @(negedge clk) begin
        if (!rst_n) begin
            cmd_ready = 0; rsp_valid = 0; pend = 0;
        end else begin
            rsp_valid = 0;
            if (pend != 0) begin
                cmd_ready = 0;
                pend--;
                if (pend == 0) begin
                    rsp_valid = 1; rsp_ack = p_ack; rsp_data = p_data;
                end
            end else begin
                cmd_ready = (($urandom % 4) != 0);
                if (cmd_valid && cmd_ready) begin
                    lg[lg_n] = {cmd_op, cmd_byte}; lg_n++;
                    p_data = 8'h00; p_ack = 1;
                    if (cmd_op == 2'd0) p_ack = !nack_start;
                    if (cmd_op == 2'd1) begin p_ack = (wr_cnt != nack_wr_at); wr_cnt++; end
                    if (cmd_op == 2'd2) begin p_data = rd_val(rd_cnt); rd_cnt++; end
                    pend = 1 + ($urandom % 3);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && ardy) ardy_seen++;
        if (rst_n && nack) nack_seen++;
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr_ctrl(logic [15:0] v);
        @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 0;
    endtask

    task automatic wr_count(logic [15:0] v);
        @(negedge clk); count_we = 1; count_wdata = v;
        @(negedge clk); count_we = 0;
    endtask

    task automatic new_test();
        @(negedge clk);
        lg_n = 0; ex_n = 0; wr_cnt = 0;
    endtask

    task automatic ex_add(logic [1:0] op, logic [7:0] b);
        ex[ex_n] = {op, b}; ex_n++;
    endtask

    task automatic wait_log(int n);
        for (int i = 0; i < 3000 && lg_n < n; i++) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic cmp_log(string tag);
        check({tag, " command count"}, lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) check({tag, " command"}, {22'd0, lg[i]}, {22'd0, ex[i]});
    endtask

    task automatic wait_xrdy(string tag);
        int k = 0;
        while (!xrdy && k < 3000) begin @(negedge clk); k++; end
        check({tag, " xrdy high while waiting"}, xrdy, 1);
    endtask

    task automatic push(logic [7:0] b);
        data_we = 1; data_wdata = b;
        @(negedge clk); data_we = 0;
    endtask

    task automatic pop_check(string tag);
        int k = 0;
        while (!rrdy && k < 3000) begin @(negedge clk); k++; end
        check({tag, " rrdy"}, rrdy, 1);
        check({tag, " rx byte"}, data_rdata, rd_val(exp_rd));
        exp_rd++;
        data_re = 1;
        @(negedge clk); data_re = 0;
    endtask

    task automatic run_tx(int n, logic [6:0] a, bit with_stop);
        logic [7:0] b;
        new_test();
        slave_addr = a;
        wr_count(16'(n));
        ex_add(2'd0, {a, 1'b0});
        wr_ctrl(with_stop ? 16'h8603 : 16'h8601);
        for (int i = 0; i < n; i++) begin
            wait_xrdy("R4");
            b = 8'($urandom);
            ex_add(2'd1, b);
            push(b);
        end
        if (with_stop) ex_add(2'd3, 8'h00);
        wait_log(ex_n);
    endtask

    task automatic run_rx(int n, logic [6:0] a);
        new_test();
        slave_addr = a;
        exp_rd = rd_cnt;
        wr_count(16'(n));
        ex_add(2'd0, {a, 1'b1});
        for (int i = 0; i < n; i++) ex_add(2'd2, 8'h00);
        ex_add(2'd3, 8'h00);
        wr_ctrl(16'h8403);
        for (int i = 0; i < n; i++) pop_check("R5");
        wait_log(ex_n);
    endtask

    initial begin
        int an, nn, n;
        void'($urandom(32'h00C0FFEE));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        check("R1 reset ctrl", ctrl_q, 0);
        check("R1 reset count", count_q, 0);
        check("R10 reset busy", busy, 0);
        check("R11 reset cmd_valid", cmd_valid, 0);
        check("R4 reset xrdy", xrdy, 0);
        check("R5 reset rrdy", rrdy, 0);

        // R1 mask; R2 10-bit setting starts nothing
        new_test();
        wr_ctrl(16'hFFFF);
        repeat (20) @(negedge clk);
        check("R1 masked ctrl", ctrl_q, 16'hCF87);
        check("R2 no command with 10-bit", lg_n, 0);
        wr_ctrl(16'h0000);
        // R2 slave mode starts nothing
        wr_ctrl(16'h8001);
        repeat (20) @(negedge clk);
        check("R2 slave-mode ctrl stored", ctrl_q, 16'h8001);
        check("R2 no command in slave mode", lg_n, 0);
        wr_ctrl(16'h0000);

        // Random counted transmits with stop
        for (int it = 0; it < 6; it++) begin
            n = 1 + ($urandom % 6);
            run_tx(n, 7'($urandom), 1);
            cmp_log("R4 R11 R2 counted tx");
            check("R6 stop/start bits cleared", ctrl_q, 16'h8600);
            check("R6 count reloaded", count_q, 16'(n));
            check("R6 bus released", busy, 0);
        end

        // Random counted receives with stop
        for (int it = 0; it < 4; it++) begin
            n = 1 + ($urandom % 7);
            run_rx(n, 7'($urandom));
            cmp_log("R5 counted rx");
            check("R5 buffer drained rrdy", rrdy, 0);
            check("R6 rx bus released", busy, 0);
        end

        // R6 zero count: START then STOP
        run_tx(0, 7'h21, 1);
        cmp_log("R6 zero count");

        // R7 no stop: access ready, master dropped, bus held, then repeated start
        an = ardy_seen;
        run_tx(2, 7'h3A, 0);
        cmp_log("R7 tx no stop");
        check("R7 ardy pulse", ardy_seen, an + 1);
        check("R7 master cleared", ctrl_q, 16'h8200);
        check("R7 bus held", busy, 1);
        check("R7 count at zero", count_q, 0);
        run_rx(2, 7'h3A);
        cmp_log("R7 repeated start rx");

        // R8 repeat transmit: count ignored, stop on request
        new_test();
        slave_addr = 7'h11;
        wr_count(16'd2);
        ex_add(2'd0, {7'h11, 1'b0});
        wr_ctrl(16'h8605);
        for (int i = 0; i < 5; i++) begin
            logic [7:0] b;
            wait_xrdy("R8");
            b = 8'($urandom);
            ex_add(2'd1, b);
            push(b);
        end
        wait_xrdy("R8");
        check("R8 count unchanged", count_q, 16'd2);
        ex_add(2'd3, 8'h00);
        wr_ctrl(16'h8606);
        wait_log(ex_n);
        cmp_log("R8 repeat tx");
        check("R8 bus released", busy, 0);

        // R8 repeat receive fills to 4; R10 abort empties buffer
        new_test();
        exp_rd = rd_cnt;
        wr_ctrl(16'h8405);
        wait_log(5);
        check("R8 repeat rx fills four", lg_n, 5);
        check("R8 rrdy with full buffer", rrdy, 1);
        check("R8 head byte", data_rdata, rd_val(exp_rd));
        wr_ctrl(16'h0000);
        @(negedge clk);
        check("R10 buffer emptied rrdy", rrdy, 0);
        check("R10 bus released", busy, 0);
        check("R10 no command", cmd_valid, 0);

        // R9 NACK on second data write
        new_test();
        nn = nack_seen;
        nack_wr_at = 1;
        slave_addr = 7'h44;
        wr_count(16'd3);
        ex_add(2'd0, {7'h44, 1'b0});
        wr_ctrl(16'h8603);
        wait_xrdy("R9");
        ex_add(2'd1, 8'hA5); push(8'hA5);
        wait_xrdy("R9");
        ex_add(2'd1, 8'h5A); push(8'h5A);
        wait_log(ex_n);
        repeat (20) @(negedge clk);
        cmp_log("R9 data nack");
        check("R9 nack pulse", nack_seen, nn + 1);
        check("R9 stop cancelled", ctrl_q, 16'h8600);
        check("R9 bus held", busy, 1);
        check("R9 no xrdy after nack", xrdy, 0);
        nack_wr_at = -1;
        wr_ctrl(16'h0000);
        check("R10 abort releases bus", busy, 0);

        // R3 NACK on start
        new_test();
        nn = nack_seen;
        nack_start = 1;
        slave_addr = 7'h55;
        wr_count(16'd2);
        ex_add(2'd0, {7'h55, 1'b0});
        wr_ctrl(16'h8603);
        wait_log(1);
        repeat (20) @(negedge clk);
        cmp_log("R3 start nack");
        check("R3 nack pulse", nack_seen, nn + 1);
        check("R3 stop cleared", ctrl_q, 16'h8600);
        check("R3 bus idle", busy, 0);
        nack_start = 0;

        finish_sim();
    end
endmodule